// File: doc/BRIEF.md
# Operand Addressing Bus Sequencer

This block produces, cycle by cycle, the memory bus traffic that an 8-bit accumulator-style processor generates between decoding an opcode and completing the operand access. A pulse on `start` hands it an addressing mode, an access kind, both index registers and the address of the byte that follows the opcode. The sequencer then drives one bus cycle per clock: the provisional operand fetch, any pointer or high-byte fetches, the dummy reads the real part would issue, and the final read, write or read-modify-write access.

The block covers zero page, zero page indexed by X or Y, absolute, absolute indexed by X or Y, pre-indexed indirect through X and post-indexed indirect through Y. The `CMOS` parameter selects the later part's behaviour at elaboration. With `CMOS` set, the middle cycle of a read-modify-write is a read rather than a write-back. The page-crossing dummy read of the Y-indirect mode goes to the operand byte address. A hold request freezes every cycle, not just reads. Read data arrives on `rd_data` and is taken at the end of the clock that presents its address. The value to store comes in on `wr_value` during the final write cycle. `done` marks the clock whose access finishes the sequence.

`start`, `hold` and `done` are plain control pins. The block has no data stream with back-pressure: `hold` is the only throttle, and the block obeys it as described in R10.

Top module: `opaddr_seq`

## Requirements
- R1: The first bus cycle after an accepted `start` is always a read at `pc_in`. It is taken as the operand byte whatever the mode. `start` is accepted only while `bus_act` is low.
- R2: Mode encoding on `mode` is 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 indirect via (ptr+X), 7 indirect then +Y. Access encoding on `acc` is 0 read, 1 write, 2 read-modify-write, and 3 is treated as read. Zero page mode accesses `{00,operand}` in the cycle after the operand read.
- R3: Zero page indexed modes first do a dummy read at `{00,operand}`. They then access `{00,(operand+index) mod 256}`, so the access never leaves page zero.
- R4: Absolute modes read the high byte from `pc_in+1` (16-bit wrap). A plain absolute access then goes to `{high,operand}`.
- R5: Absolute indexed reads whose index addition leaves the high byte unchanged access the indexed address straight after the high-byte fetch. If the high byte changes, a dummy read at `{original high, new low}` comes first.
- R6: Indexed writes and read-modify-writes (absolute indexed and Y-indirect) always take the extra dummy cycle, page crossing or not.
- R7: Indirect via X does a dummy read at `{00,ptr}`, then reads the low byte at `{00,ptr+X}` and the high byte at `{00,ptr+X+1}`, both wrapping in page zero, then does the access.
- R8: Indirect then Y reads the low and high bytes at `{00,ptr}` and `{00,ptr+1}` (page-zero wrap) and adds Y, following the R5/R6 rule for the extra cycle. Its dummy read goes to `{original high, new low}` when `CMOS`=0 and to `pc_in` when `CMOS`=1.
- R9: A read-modify-write is a read of the effective address, then a stall cycle at the same address, then a write of `wr_value`. When `CMOS`=0 the stall cycle writes back the byte just read. When `CMOS`=1 the stall cycle is a read.
- R10: While `hold` is high, a read cycle repeats with the same address and the sequence does not advance. With `CMOS`=1 every cycle repeats. With `CMOS`=0 write cycles complete despite `hold`.
- R11: `done` is high for exactly the one clock in which the final access completes, and the bus is idle in the next clock. A `start` while busy has no effect on the sequence in progress.
- R12: After reset, and whenever idle, `bus_act`, `bus_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode | input | 3 | Addressing mode, encoding in R2 |
| acc | input | 2 | Access kind, encoding in R2 |
| idx_x | input | 8 | X index, captured on start |
| idx_y | input | 8 | Y index, captured on start |
| pc_in | input | 16 | Address of the byte after the opcode, captured on start |
| hold | input | 1 | Stall request |
| rd_data | input | 8 | Read data for the current cycle |
| wr_value | input | 8 | Value stored by the final write |
| bus_act | output | 1 | A bus cycle is presented this clock |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | 1 write, 0 read |
| bus_wdata | output | 8 | Write data (zero on reads) |
| done | output | 1 | Final access completes this clock |

## Verification
Each mode runs with every access kind on both variants, against a cycle list the bench builds from the rules above. Random pointers, index values and program addresses make page crossings sometimes happen and sometimes not. Directed cases pin the boundaries: an index that carries out of the low byte against one that does not, a zero page index that wraps past 0xFF, and a pointer at 0xFF whose high byte wraps to 0x00. Read-modify-write runs on both variants separate the write-back stall from the read stall, and the Y-indirect crossing case shows the different dummy address. Random `hold` pulses show which cycles repeat on each variant. Stray `start` pulses and mode changes during a busy sequence must leave the trace unchanged.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    AM_ZP   = 3'd0,
    AM_ZPX  = 3'd1,
    AM_ZPY  = 3'd2,
    AM_ABS  = 3'd3,
    AM_ABSX = 3'd4,
    AM_ABSY = 3'd5,
    AM_INDX = 3'd6,
    AM_INDY = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    AK_RD  = 2'd0,
    AK_WR  = 2'd1,
    AK_RMW = 2'd2
  } akind_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_OPER  = 4'd1,
    ST_ZDUM  = 4'd2,
    ST_HIGH  = 4'd3,
    ST_PLO   = 4'd4,
    ST_PHI   = 4'd5,
    ST_FIXUP = 4'd6,
    ST_ACCR  = 4'd7,
    ST_STALL = 4'd8,
    ST_ACCW  = 4'd9
  } seq_st_e;

  function automatic akind_e kind_of(input logic [1:0] raw);
    case (raw)
      2'd1:    return AK_WR;
      2'd2:    return AK_RMW;
      default: return AK_RD;
    endcase
  endfunction

  // index added inside page zero
  function automatic logic zp_uses_x(input amode_e m);
    return m == AM_ZPX;
  endfunction

  function automatic logic zp_uses_y(input amode_e m);
    return m == AM_ZPY;
  endfunction

  // index added to a full 16-bit base
  function automatic logic wide_uses_x(input amode_e m);
    return m == AM_ABSX;
  endfunction

  function automatic logic wide_uses_y(input amode_e m);
    return (m == AM_ABSY) || (m == AM_INDY);
  endfunction

endpackage

// File: rtl/opaddr_fsm.sv
module opaddr_fsm
  import opaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] mode,
  input  logic [1:0] acc,
  input  logic       page_cross,
  input  logic       step,
  output seq_st_e    st,
  output amode_e     mode_q,
  output akind_e     kind_q,
  output logic       done
);

  seq_st_e nxt;
  seq_st_e acc_first;
  seq_st_e fix_or_go;

  always_comb begin
    acc_first = (kind_q == AK_WR) ? ST_ACCW : ST_ACCR;
    // only a plain read without a carry may skip the extra cycle
    fix_or_go = (kind_q == AK_RD && !page_cross) ? acc_first : ST_FIXUP;
  end

  always_comb begin
    nxt  = st;
    done = 1'b0;
    case (st)
      ST_IDLE: if (start) nxt = ST_OPER;
      ST_OPER: begin
        case (mode_q)
          AM_ZP:                    nxt = acc_first;
          AM_ZPX, AM_ZPY, AM_INDX:  nxt = ST_ZDUM;
          AM_INDY:                  nxt = ST_PLO;
          default:                  nxt = ST_HIGH;
        endcase
      end
      ST_ZDUM:  nxt = (mode_q == AM_INDX) ? ST_PLO : acc_first;
      ST_HIGH:  nxt = (mode_q == AM_ABS) ? acc_first : fix_or_go;
      ST_PLO:   nxt = ST_PHI;
      ST_PHI:   nxt = (mode_q == AM_INDX) ? acc_first : fix_or_go;
      ST_FIXUP: nxt = acc_first;
      ST_ACCR: begin
        if (kind_q == AK_RMW) nxt = ST_STALL;
        else begin
          nxt  = ST_IDLE;
          done = step;
        end
      end
      ST_STALL: nxt = ST_ACCW;
      ST_ACCW: begin
        nxt  = ST_IDLE;
        done = step;
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= AM_ZP;
      kind_q <= AK_RD;
    end else if (st == ST_IDLE) begin
      st <= nxt;
      if (start) begin
        mode_q <= amode_e'(mode);
        kind_q <= kind_of(acc);
      end
    end else if (step) begin
      st <= nxt;
    end
  end

endmodule

// File: rtl/opaddr_path.sv
module opaddr_path
  import opaddr_pkg::*;
#(
  parameter bit CMOS   = 1'b0,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              step,
  input  seq_st_e           st,
  input  amode_e            mode_q,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_value,
  output logic              bus_act,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              page_cross
);

  localparam logic [DATA_W-1:0] ZERO_PAGE = '0;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] x_q, y_q;
  logic [DATA_W-1:0] op_q, lo_q, hi_q, ptr_q, rdv_q;
  logic [ADDR_W-1:0] eff_q;
  logic [DATA_W-1:0] zidx, widx;
  logic [DATA_W:0]   lo_sum;

  always_comb begin
    zidx = '0;
    if (zp_uses_x(mode_q)) zidx = x_q;
    if (zp_uses_y(mode_q)) zidx = y_q;
    widx = '0;
    if (wide_uses_x(mode_q)) widx = x_q;
    if (wide_uses_y(mode_q)) widx = y_q;
    lo_sum     = {1'b0, lo_q} + {1'b0, widx};
    page_cross = lo_sum[DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      x_q   <= '0;
      y_q   <= '0;
      op_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      ptr_q <= '0;
      rdv_q <= '0;
      eff_q <= '0;
    end else if (accept) begin
      pc_q <= pc_in;
      x_q  <= idx_x;
      y_q  <= idx_y;
    end else if (step) begin
      case (st)
        ST_OPER: begin
          op_q  <= rd_data;
          lo_q  <= rd_data;
          ptr_q <= rd_data;
          eff_q <= {ZERO_PAGE, rd_data};
        end
        ST_ZDUM: begin
          eff_q <= {ZERO_PAGE, op_q + zidx};
          ptr_q <= op_q + x_q;
        end
        ST_HIGH, ST_PHI: begin
          hi_q  <= rd_data;
          eff_q <= {rd_data, lo_q} + {ZERO_PAGE, widx};
        end
        ST_PLO:  lo_q  <= rd_data;
        ST_ACCR: rdv_q <= rd_data;
        default: ;
      endcase
    end
  end

  generate
    if (CMOS) begin : g_late
      always_comb begin
        bus_we = (st == ST_ACCW);
      end
    end else begin : g_early
      always_comb begin
        bus_we = (st == ST_ACCW) || (st == ST_STALL);
      end
    end
  endgenerate

  always_comb begin
    bus_act  = (st != ST_IDLE);
    bus_addr = '0;
    case (st)
      ST_OPER:  bus_addr = pc_q;
      ST_ZDUM:  bus_addr = {ZERO_PAGE, op_q};
      ST_HIGH:  bus_addr = pc_q + ADDR_W'(1);
      ST_PLO:   bus_addr = {ZERO_PAGE, ptr_q};
      ST_PHI:   bus_addr = {ZERO_PAGE, ptr_q + DATA_W'(1)};
      ST_FIXUP: bus_addr = (CMOS && mode_q == AM_INDY) ? pc_q
                                                       : {hi_q, eff_q[DATA_W-1:0]};
      ST_ACCR, ST_STALL, ST_ACCW: bus_addr = eff_q;
      default:  bus_addr = '0;
    endcase
    bus_wdata = '0;
    if (st == ST_ACCW)                bus_wdata = wr_value;
    else if (st == ST_STALL && !CMOS) bus_wdata = rdv_q;
  end

endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
  import opaddr_pkg::*;
#(
  parameter bit CMOS   = 1'b0,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        acc,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              hold,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] wr_value,
  output logic              bus_act,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done
);

  seq_st_e st;
  amode_e  mode_q;
  akind_e  kind_q;
  logic    page_cross;
  logic    stall;
  logic    step;
  logic    accept;

  always_comb begin
    stall  = hold && (CMOS || !bus_we);
    step   = bus_act && !stall;
    accept = start && (st == ST_IDLE);
  end

  opaddr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .acc        (acc),
    .page_cross (page_cross),
    .step       (step),
    .st         (st),
    .mode_q     (mode_q),
    .kind_q     (kind_q),
    .done       (done)
  );

  opaddr_path #(
    .CMOS   (CMOS),
    .DATA_W (DATA_W)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .step       (step),
    .st         (st),
    .mode_q     (mode_q),
    .pc_in      (pc_in),
    .idx_x      (idx_x),
    .idx_y      (idx_y),
    .rd_data    (rd_data),
    .wr_value   (wr_value),
    .bus_act    (bus_act),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .page_cross (page_cross)
  );

endmodule

// File: rtl/opaddr_seq_chk.sv
module opaddr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc_in,
  input logic              hold,
  input logic              bus_act,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              done
);

  // R1: a fresh sequence opens with a read at the captured program address
  a_r1_first_reads_pc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_act) |-> (!bus_we && bus_addr == $past(pc_in)));

  // R10: a held read repeats at the same address
  a_r10_held_read_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !bus_we && hold) |=> (bus_act && $stable(bus_addr)));

  // R10: a held read never completes the sequence
  a_r10_held_read_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && !bus_we && hold) |-> !done);

  // R11: done is a single pulse followed by an idle bus
  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!bus_act && !done));

  // R12: an idle bus neither writes nor signals completion
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_act |-> (!bus_we && !done));

endmodule

bind opaddr_seq opaddr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_in    (pc_in),
  .hold     (hold),
  .bus_act  (bus_act),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .done     (done)
);

// File: tb/opaddr_seq_bench.sv
module opaddr_seq_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        start0, start1;
  logic [2:0]  mode;
  logic [1:0]  acc;
  logic [7:0]  ix, iy, wv, salt;
  logic [15:0] pc;
  logic        hold;

  logic        act0, act1, we0, we1, dn0, dn1;
  logic [15:0] a0, a1;
  logic [7:0]  wd0, wd1, rd0, rd1;

  // bench memory: a salted hash of the address
  assign rd0 = a0[7:0] ^ {a0[14:8], a0[15]} ^ salt;
  assign rd1 = a1[7:0] ^ {a1[14:8], a1[15]} ^ salt;

  opaddr_seq #(.CMOS(1'b0)) u_opaddr_seq (
    .clk(clk), .rst_n(rst_n), .start(start0), .mode(mode), .acc(acc),
    .idx_x(ix), .idx_y(iy), .pc_in(pc), .hold(hold), .rd_data(rd0),
    .wr_value(wv), .bus_act(act0), .bus_addr(a0), .bus_we(we0),
    .bus_wdata(wd0), .done(dn0));

  opaddr_seq #(.CMOS(1'b1)) u_opaddr_seq_c (
    .clk(clk), .rst_n(rst_n), .start(start1), .mode(mode), .acc(acc),
    .idx_x(ix), .idx_y(iy), .pc_in(pc), .hold(hold), .rd_data(rd1),
    .wr_value(wv), .bus_act(act1), .bus_addr(a1), .bus_we(we1),
    .bus_wdata(wd1), .done(dn1));

  bit          sel;
  logic        s_act, s_we, s_dn;
  logic [15:0] s_addr;
  logic [7:0]  s_wd;
  always_comb begin
    s_act  = sel ? act1 : act0;
    s_we   = sel ? we1  : we0;
    s_dn   = sel ? dn1  : dn0;
    s_addr = sel ? a1   : a0;
    s_wd   = sel ? wd1  : wd0;
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ salt;
  endfunction

  logic [15:0] e_addr [0:15];
  logic        e_we   [0:15];
  logic [7:0]  e_wd   [0:15];
  int          e_n;
  string       e_req;

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d);
    e_addr[e_n] = a;
    e_we[e_n]   = w;
    e_wd[e_n]   = d;
    e_n++;
  endtask

  // expected cycle list built from R1..R9
  task automatic build(input bit v, input logic [2:0] m, input logic [1:0] t,
                       input logic [15:0] p, input logic [7:0] xv,
                       input logic [7:0] yv, input logic [7:0] w);
    logic [7:0]  op, hi, lo, ptr, idx;
    logic [15:0] eff, sum;
    bit          rd_only;
    rd_only = (t == 2'd0) || (t == 2'd3);
    e_n = 0;
    op  = memf(p);
    push(p, 1'b0, 8'h00);
    eff = {8'h00, op};
    e_req = "R2";
    case (m)
      3'd1, 3'd2: begin
        e_req = "R3";
        idx = (m == 3'd1) ? xv : yv;
        push({8'h00, op}, 1'b0, 8'h00);
        eff = {8'h00, op + idx};
      end
      3'd3: begin
        e_req = "R4";
        push(p + 16'd1, 1'b0, 8'h00);
        eff = {memf(p + 16'd1), op};
      end
      3'd4, 3'd5: begin
        e_req = rd_only ? "R5" : "R6";
        idx = (m == 3'd4) ? xv : yv;
        push(p + 16'd1, 1'b0, 8'h00);
        hi  = memf(p + 16'd1);
        sum = {hi, op} + {8'h00, idx};
        if (!(rd_only && sum[15:8] == hi)) push({hi, sum[7:0]}, 1'b0, 8'h00);
        eff = sum;
      end
      3'd6: begin
        e_req = "R7";
        push({8'h00, op}, 1'b0, 8'h00);
        ptr = op + xv;
        push({8'h00, ptr}, 1'b0, 8'h00);
        lo = memf({8'h00, ptr});
        ptr = ptr + 8'd1;
        push({8'h00, ptr}, 1'b0, 8'h00);
        hi  = memf({8'h00, ptr});
        eff = {hi, lo};
      end
      3'd7: begin
        e_req = "R8";
        push({8'h00, op}, 1'b0, 8'h00);
        lo  = memf({8'h00, op});
        ptr = op + 8'd1;
        push({8'h00, ptr}, 1'b0, 8'h00);
        hi  = memf({8'h00, ptr});
        sum = {hi, lo} + {8'h00, yv};
        if (!(rd_only && sum[15:8] == hi))
          push(v ? p : {hi, sum[7:0]}, 1'b0, 8'h00);
        eff = sum;
      end
      default: ;
    endcase
    if (t == 2'd1) push(eff, 1'b1, w);
    else if (t == 2'd2) begin
      e_req = "R9";
      push(eff, 1'b0, 8'h00);
      push(eff, !v, v ? 8'h00 : memf(eff));
      push(eff, 1'b1, w);
    end else push(eff, 1'b0, 8'h00);
  endtask

  task automatic run_one(input bit v, input logic [2:0] m, input logic [1:0] t,
                         input logic [15:0] p, input logic [7:0] xv,
                         input logic [7:0] yv, input bit hold_en,
                         input bit busy_start);
    int  idx;
    int  guard;
    bit  rep;
    logic [7:0] w;
    w = 8'($urandom);
    build(v, m, t, p, xv, yv, w);
    @(negedge clk);
    sel = v; mode = m; acc = t; pc = p; ix = xv; iy = yv; wv = w; hold = 1'b0;
    start0 = !v; start1 = v;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    idx = 0;
    guard = 0;
    while (idx < e_n && guard < 200) begin
      guard++;
      hold = hold_en && ($urandom_range(3) == 0);
      if (busy_start && idx == 2) begin
        // R11: start while busy, with a different mode on the pins
        start0 = !v; start1 = v; mode = 3'($urandom);
      end else begin
        start0 = 1'b0; start1 = 1'b0;
      end
      #1;
      check(s_act == 1'b1, "R11", "bus_act during sequence", 32'(s_act), 32'd1);
      check(s_addr == e_addr[idx], (idx == 0) ? "R1" : e_req, "bus_addr",
            32'(s_addr), 32'(e_addr[idx]));
      check(s_we == e_we[idx], (idx == 0) ? "R1" : e_req, "bus_we",
            32'(s_we), 32'(e_we[idx]));
      if (e_we[idx])
        check(s_wd == e_wd[idx], e_req, "bus_wdata", 32'(s_wd), 32'(e_wd[idx]));
      rep = hold && (v || !e_we[idx]);  // R10 repeat rule
      check(s_dn == (!rep && idx == e_n - 1), rep ? "R10" : "R11", "done",
            32'(s_dn), 32'(!rep && idx == e_n - 1));
      if (!rep) idx++;
      @(negedge clk);
    end
    start0 = 1'b0; start1 = 1'b0; hold = 1'b0;
    #1;
    check(!s_act && !s_dn, "R11", "idle after final access",
          32'({s_act, s_dn}), 32'd0);
  endtask

  task automatic directed(input bit v, input logic [2:0] m, input logic [1:0] t,
                          input logic [15:0] p, input logic [7:0] op_want,
                          input logic [7:0] xv, input logic [7:0] yv);
    @(negedge clk);
    salt = op_want ^ p[7:0] ^ {p[14:8], p[15]};
    run_one(v, m, t, p, xv, yv, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start0 = 1'b0; start1 = 1'b0; mode = '0; acc = '0;
    ix = '0; iy = '0; wv = '0; pc = '0; hold = 1'b0; salt = 8'h3c; sel = 1'b0;
    repeat (3) @(negedge clk);
    // R12: quiet after reset
    check(!act0 && !we0 && !dn0, "R12", "reset state nmos",
          32'({act0, we0, dn0}), 32'd0);
    check(!act1 && !we1 && !dn1, "R12", "reset state cmos",
          32'({act1, we1, dn1}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!act0 && !act1, "R12", "idle after reset release",
          32'({act0, act1}), 32'd0);

    directed(1'b0, 3'd0, 2'd0, 16'h0400, 8'h80, 8'h00, 8'h00); // R2 zp read
    directed(1'b0, 3'd1, 2'd0, 16'h1200, 8'hF0, 8'h20, 8'h00); // R3 zp wrap
    directed(1'b1, 3'd2, 2'd1, 16'h1200, 8'hFF, 8'h00, 8'h01); // R3 zp+y wrap
    directed(1'b0, 3'd3, 2'd0, 16'hFFFF, 8'h55, 8'h00, 8'h00); // R4 pc+1 wrap
    directed(1'b0, 3'd4, 2'd0, 16'h1234, 8'hFF, 8'h01, 8'h00); // R5 cross
    directed(1'b0, 3'd4, 2'd0, 16'h1234, 8'h10, 8'h01, 8'h00); // R5 shortcut
    directed(1'b0, 3'd4, 2'd1, 16'h1234, 8'h10, 8'h01, 8'h00); // R6 write
    directed(1'b1, 3'd5, 2'd2, 16'h2000, 8'h10, 8'h00, 8'h01); // R6 rmw
    directed(1'b0, 3'd6, 2'd0, 16'h3000, 8'hFE, 8'h01, 8'h00); // R7 wrap
    directed(1'b0, 3'd7, 2'd0, 16'h3000, 8'hFF, 8'h00, 8'hFF); // R8 nmos
    directed(1'b1, 3'd7, 2'd0, 16'h3000, 8'hFF, 8'h00, 8'hFF); // R8 cmos
    directed(1'b0, 3'd0, 2'd2, 16'h0500, 8'h42, 8'h00, 8'h00); // R9 nmos
    directed(1'b1, 3'd0, 2'd2, 16'h0500, 8'h42, 8'h00, 8'h00); // R9 cmos

    for (int k = 0; k < 400; k++) begin
      salt = 8'($urandom);
      run_one(bit'($urandom_range(1)), 3'($urandom), 2'($urandom),
              16'($urandom), 8'($urandom), 8'($urandom),
              1'b1, ($urandom_range(4) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule